// File: doc/BRIEF.md
# Speculative Write-Update Policy Engine

This block sits beside a writing cache and decides when a write should also push its new value into the stale (invalid) copies that other caches still hold for the same block. Those stale copies are only used for speculative reads, so the pushed data is a hint. It never takes part in correctness, and the coherence protocol stays invalidation based. The engine watches local writes to shared blocks together with the sharer mask, and it watches the outgoing invalidation messages. It produces update messages under a policy chosen at run time.

There are two kinds of output. A piggybacked update rides on an invalidation that is already leaving. It is flagged in the same cycle and uses that invalidation's valid handshake. A standalone update is a registered message that carries the block address, word offset, data and sharer mask, and it waits for its own ready. The policy select picks one of these modes:

- off;
- piggyback on every invalidation;
- piggyback only when the value compresses;
- standalone after every N writes to a block, counted per block in a small table;
- standalone on every write that has sharers.

Top module: `wu_policy_engine`

## Requirements
- R1: After reset `upd_valid_o` is 0, `pb_attach_o` is 0, and every per-block write count is 0.
- R2: `policy_i` encodes 0 = off, 1 = piggyback all, 2 = piggyback compressed, 3 = every-N, 4 = every-write. Values 0, 5, 6 and 7 produce no piggyback flag and load no standalone update.
- R3: With policy 1, `pb_attach_o` is 1 in the same cycle as `inv_valid_i` with a nonzero `inv_mask_i`. In that case `pb_data_o` equals `inv_data_i`.
- R4: With policy 2, the flag is raised only when bits [31:8] of `inv_data_i` are all 0 or all 1.
- R5: With policy 3, each write with sharers increments a counter. The counter is selected by `wr_addr_i[3:0]` in a 16-entry table. The write that brings the count to N loads a standalone update, and that counter returns to 0.
- R6: With policy 4, every write with a nonzero `wr_sharers_i` loads a standalone update. The update is visible after the next clock edge and carries the write's address, offset, data and sharer mask.
- R7: An `every_n_i` value of 0 behaves as N = 1.
- R8: A zero sharer mask never produces a message under any policy. In policy 3, such a write is not counted.
- R9: A standalone update holds valid and all its fields stable until `upd_ready_i`. An update triggered while one is held and `upd_ready_i` is 0 is dropped.
- R10: Piggyback policies (1, 2) never load a standalone update. Standalone policies (3, 4) never raise `pb_attach_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 3 | Update policy select |
| every_n_i | input | 4 | Write count N for policy 3 (0 acts as 1) |
| wr_valid_i | input | 1 | Local write to a shared block |
| wr_addr_i | input | 26 | Block address of the write |
| wr_offset_i | input | 4 | Word offset of the write |
| wr_data_i | input | 32 | Written word |
| wr_sharers_i | input | 16 | Other caches holding the block |
| inv_valid_i | input | 1 | Outgoing invalidation valid |
| inv_data_i | input | 32 | Word written by the invalidating store |
| inv_mask_i | input | 16 | Targets of the invalidation |
| pb_attach_o | output | 1 | Attach data to the current invalidation |
| pb_data_o | output | 32 | Data to attach (0 when not attaching) |
| upd_valid_o | output | 1 | Standalone update valid |
| upd_ready_i | input | 1 | Standalone update accepted |
| upd_addr_o | output | 26 | Update block address |
| upd_offset_o | output | 4 | Update word offset |
| upd_data_o | output | 32 | Update data |
| upd_mask_o | output | 16 | Caches to update |

## Verification
Piggyback results are combinational. The bench drives an invalidation on a falling edge and samples `pb_attach_o` and `pb_data_o` one nanosecond later, before any rising edge. Standalone results pass through one register. Each write is held across exactly one rising edge, and the update is sampled on the falling edge that follows. In every-N mode, the expected hit is worked out by counting the writes to each table index. Under back-pressure the held message is re-sampled on each falling edge until one edge after `upd_ready_i` returns to 1.

// File: rtl/wu_pkg.sv
package wu_pkg;
  typedef enum logic [2:0] {
    POL_OFF      = 3'd0,
    POL_PB_ALL   = 3'd1,
    POL_PB_CMP   = 3'd2,
    POL_EVERY_N  = 3'd3,
    POL_EVERY_WR = 3'd4
  } policy_e;
endpackage

// File: rtl/wu_compress_chk.sv
module wu_compress_chk #(
  parameter int DATA_W = 32,
  parameter int KEEP_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              ok_o
);
  localparam int HI_W = DATA_W - KEEP_W;
  logic [HI_W-1:0] hi;
  assign hi   = data_i[DATA_W-1:KEEP_W];
  assign ok_o = (hi == '0) || (&hi);
endmodule

// File: rtl/wu_write_counter.sv
module wu_write_counter #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] n_eff;
  logic [CNT_W:0]   nxt;

  assign n_eff  = (n_i == '0) ? CNT_W'(1) : n_i;
  assign nxt    = {1'b0, cnt_q[idx_i]} + (CNT_W+1)'(1);
  // >= so a lowered N fires on the next counted write
  assign fire_o = inc_i && (nxt >= {1'b0, n_eff});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
    end else if (inc_i) begin
      cnt_q[idx_i] <= fire_o ? '0 : nxt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/wu_update_stage.sv
module wu_update_stage #(
  parameter int ADDR_W = 26,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 32,
  parameter int NODES  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NODES-1:0]  mask_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic [DATA_W-1:0] data_o,
  output logic [NODES-1:0]  mask_o
);
  logic free;
  assign free = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      addr_o   <= '0;
      offset_o <= '0;
      data_o   <= '0;
      mask_o   <= '0;
    end else if (load_i && free) begin
      valid_o  <= 1'b1;
      addr_o   <= addr_i;
      offset_o <= offset_i;
      data_o   <= data_i;
      mask_o   <= mask_i;
    end else if (ready_i) begin
      valid_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/wu_policy_engine.sv
module wu_policy_engine
  import wu_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int OFF_W   = 4,
  parameter int DATA_W  = 32,
  parameter int NODES   = 16,
  parameter int TBL_DEP = 16,
  parameter int N_W     = 4,
  parameter int KEEP_W  = 8,
  localparam int IDX_W  = $clog2(TBL_DEP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        policy_i,
  input  logic [N_W-1:0]    every_n_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [OFF_W-1:0]  wr_offset_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NODES-1:0]  wr_sharers_i,
  input  logic              inv_valid_i,
  input  logic [DATA_W-1:0] inv_data_i,
  input  logic [NODES-1:0]  inv_mask_i,
  output logic              pb_attach_o,
  output logic [DATA_W-1:0] pb_data_o,
  output logic              upd_valid_o,
  input  logic              upd_ready_i,
  output logic [ADDR_W-1:0] upd_addr_o,
  output logic [OFF_W-1:0]  upd_offset_o,
  output logic [DATA_W-1:0] upd_data_o,
  output logic [NODES-1:0]  upd_mask_o
);
  logic pol_pb_all, pol_pb_cmp, pol_n, pol_wr;
  logic cmp_ok, inv_live, wr_live;
  logic cnt_inc, cnt_fire, upd_load;

  always_comb begin
    pol_pb_all = 1'b0;
    pol_pb_cmp = 1'b0;
    pol_n      = 1'b0;
    pol_wr     = 1'b0;
    case (policy_i)
      POL_PB_ALL:   pol_pb_all = 1'b1;
      POL_PB_CMP:   pol_pb_cmp = 1'b1;
      POL_EVERY_N:  pol_n      = 1'b1;
      POL_EVERY_WR: pol_wr     = 1'b1;
      default: ;
    endcase
  end

  wu_compress_chk #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_cmp (
    .data_i (inv_data_i),
    .ok_o   (cmp_ok)
  );

  assign inv_live    = inv_valid_i && (|inv_mask_i);
  assign pb_attach_o = inv_live && (pol_pb_all || (pol_pb_cmp && cmp_ok));
  assign pb_data_o   = pb_attach_o ? inv_data_i : '0;

  assign wr_live = wr_valid_i && (|wr_sharers_i);
  assign cnt_inc = wr_live && pol_n;

  wu_write_counter #(.DEPTH(TBL_DEP), .CNT_W(N_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (cnt_inc),
    .idx_i  (wr_addr_i[IDX_W-1:0]),
    .n_i    (every_n_i),
    .fire_o (cnt_fire)
  );

  assign upd_load = wr_live && (pol_wr || (pol_n && cnt_fire));

  wu_update_stage #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .NODES(NODES)
  ) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (upd_load),
    .addr_i   (wr_addr_i),
    .offset_i (wr_offset_i),
    .data_i   (wr_data_i),
    .mask_i   (wr_sharers_i),
    .ready_i  (upd_ready_i),
    .valid_o  (upd_valid_o),
    .addr_o   (upd_addr_o),
    .offset_o (upd_offset_o),
    .data_o   (upd_data_o),
    .mask_o   (upd_mask_o)
  );
endmodule

// File: rtl/wu_policy_engine_chk.sv
module wu_policy_engine_chk #(
  parameter int ADDR_W = 26,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 32,
  parameter int NODES  = 16,
  parameter int N_W    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        policy_i,
  input logic [N_W-1:0]    every_n_i,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [OFF_W-1:0]  wr_offset_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [NODES-1:0]  wr_sharers_i,
  input logic              inv_valid_i,
  input logic [DATA_W-1:0] inv_data_i,
  input logic [NODES-1:0]  inv_mask_i,
  input logic              pb_attach_o,
  input logic [DATA_W-1:0] pb_data_o,
  input logic              upd_valid_o,
  input logic              upd_ready_i,
  input logic [ADDR_W-1:0] upd_addr_o,
  input logic [OFF_W-1:0]  upd_offset_o,
  input logic [DATA_W-1:0] upd_data_o,
  input logic [NODES-1:0]  upd_mask_o
);
  assert_off_no_pb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 3'd0 || policy_i > 3'd4) |-> !pb_attach_o);

  assert_pb_only_pb_modes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_attach_o |-> (policy_i == 3'd1 || policy_i == 3'd2));

  assert_pb_needs_targets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_attach_o |-> (inv_valid_i && (|inv_mask_i)));

  assert_upd_mask_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (|upd_mask_o));

  assert_upd_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(upd_valid_o) |->
      $past(wr_valid_i && (|wr_sharers_i) && (policy_i == 3'd3 || policy_i == 3'd4)));

  assert_upd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_o && !upd_ready_i) |=>
      (upd_valid_o && $stable(upd_addr_o) && $stable(upd_offset_o) &&
       $stable(upd_data_o) && $stable(upd_mask_o)));
endmodule

bind wu_policy_engine wu_policy_engine_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .NODES(NODES), .N_W(N_W)
) u_chk (.*);

// File: tb/wu_policy_engine_test.sv
module wu_policy_engine_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  policy_i = '0;
  logic [3:0]  every_n_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [25:0] wr_addr_i = '0;
  logic [3:0]  wr_offset_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [15:0] wr_sharers_i = '0;
  logic        inv_valid_i = 1'b0;
  logic [31:0] inv_data_i = '0;
  logic [15:0] inv_mask_i = '0;
  logic        pb_attach_o;
  logic [31:0] pb_data_o;
  logic        upd_valid_o;
  logic        upd_ready_i = 1'b1;
  logic [25:0] upd_addr_o;
  logic [3:0]  upd_offset_o;
  logic [31:0] upd_data_o;
  logic [15:0] upd_mask_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  wu_policy_engine uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [25:0] a, logic [3:0] o, logic [31:0] d, logic [15:0] m);
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_offset_i = o; wr_data_i = d; wr_sharers_i = m;
    @(negedge clk_i);
    wr_valid_i = 1'b0; wr_sharers_i = '0;
  endtask

  task automatic probe(string req, logic [31:0] d, logic [15:0] m, bit exp_att);
    @(negedge clk_i);
    inv_valid_i = 1'b1; inv_data_i = d; inv_mask_i = m;
    #1;
    check(req, pb_attach_o, exp_att);
    check(req, pb_data_o, exp_att ? d : 32'h0);
    inv_valid_i = 1'b0; inv_mask_i = '0;
  endtask

  task automatic t_reset();
    check("R1 upd_valid", upd_valid_o, 0);
    check("R1 pb_attach", pb_attach_o, 0);
  endtask

  task automatic t_off();
    policy_i = 3'd0;
    probe("R2 off pb", 32'h12345678, 16'h0003, 0);
    wr(26'h10, 4'd1, 32'h1, 16'h0003);
    check("R2 off upd", upd_valid_o, 0);
    policy_i = 3'd6;
    probe("R2 code6 pb", 32'h00000001, 16'h0001, 0);
    wr(26'h11, 4'd1, 32'h1, 16'h0001);
    check("R2 code6 upd", upd_valid_o, 0);
  endtask

  task automatic t_pb_all();
    policy_i = 3'd1;
    probe("R3 pb all", 32'h12345678, 16'h0003, 1);
    probe("R8 pb zero mask", 32'h12345678, 16'h0000, 0);
    wr(26'h20, 4'd2, 32'h5, 16'h0004);
    check("R10 pb mode no upd", upd_valid_o, 0);
  endtask

  task automatic t_pb_cmp();
    policy_i = 3'd2;
    probe("R4 zeros", 32'h000000FF, 16'h0001, 1);
    probe("R4 ones", 32'hFFFFFF00, 16'h0001, 1);
    probe("R4 bit8", 32'h00000100, 16'h0001, 0);
    probe("R4 mixed", 32'hFFFEFFFF, 16'h0001, 0);
    probe("R4 msb", 32'h80000000, 16'h0001, 0);
  endtask

  task automatic t_every_wr();
    policy_i = 3'd4;
    wr(26'h123456, 4'd5, 32'hCAFEF00D, 16'h8001);
    check("R6 valid", upd_valid_o, 1);
    check("R6 addr", upd_addr_o, 26'h123456);
    check("R6 offset", upd_offset_o, 4'd5);
    check("R6 data", upd_data_o, 32'hCAFEF00D);
    check("R6 mask", upd_mask_o, 16'h8001);
    @(negedge clk_i);
    check("R6 consumed", upd_valid_o, 0);
    probe("R10 wr mode no pb", 32'h00000001, 16'h0001, 0);
    wr(26'h30, 4'd0, 32'h7, 16'h0000);
    check("R8 zero mask upd", upd_valid_o, 0);
  endtask

  task automatic t_every_n();
    policy_i = 3'd3; every_n_i = 4'd3;
    probe("R10 n mode no pb", 32'h00000001, 16'h0001, 0);
    wr(26'h42, 4'd0, 32'hA1, 16'h0002);
    check("R5 w1", upd_valid_o, 0);
    wr(26'h42, 4'd0, 32'hA2, 16'h0002);
    check("R5 w2", upd_valid_o, 0);
    wr(26'h42, 4'd1, 32'hA3, 16'h0002);
    check("R5 w3 fires", upd_valid_o, 1);
    check("R5 w3 data", upd_data_o, 32'hA3);
    wr(26'h43, 4'd0, 32'hB1, 16'h0002);
    check("R5 other index", upd_valid_o, 0);
    wr(26'h42, 4'd0, 32'hA4, 16'h0002);
    check("R5 reset count", upd_valid_o, 0);
    wr(26'h42, 4'd0, 32'hA5, 16'h0000);
    check("R8 zero mask not counted", upd_valid_o, 0);
    wr(26'h52, 4'd3, 32'hC1, 16'h0002);
    check("R5 aliased index", upd_valid_o, 0);
    wr(26'h42, 4'd2, 32'hA6, 16'h0004);
    check("R5 third counted fires", upd_valid_o, 1);
    check("R5 fire addr", upd_addr_o, 26'h42);
    check("R5 fire mask", upd_mask_o, 16'h0004);
  endtask

  task automatic t_n_zero();
    policy_i = 3'd3; every_n_i = 4'd0;
    for (int i = 0; i < 3; i++) begin
      wr(26'h7, 4'd0, 32'(i), 16'h0001);
      check("R7 N0 every write", upd_valid_o, 1);
    end
  endtask

  task automatic t_backpressure();
    policy_i = 3'd4;
    @(negedge clk_i);
    upd_ready_i = 1'b0;
    wr(26'h100, 4'd1, 32'h11111111, 16'h0010);
    check("R9 held valid", upd_valid_o, 1);
    wr(26'h200, 4'd2, 32'h22222222, 16'h0020);
    check("R9 dropped keeps data", upd_data_o, 32'h11111111);
    check("R9 dropped keeps addr", upd_addr_o, 26'h100);
    @(negedge clk_i);
    check("R9 still held", upd_valid_o, 1);
    upd_ready_i = 1'b1;
    @(negedge clk_i);
    check("R9 released", upd_valid_o, 0);
    @(negedge clk_i);
    check("R9 no late second", upd_valid_o, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_off();
    t_pb_all();
    t_pb_cmp();
    t_every_wr();
    t_every_n();
    t_n_zero();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule